// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block paces the conversions of an analog-to-digital converter. Software writes a single start/status bit. Writing a 1 while the sequencer is idle and continuous mode is off launches one conversion. Writing a 0 does nothing. Reading the same bit, which is the `busy_o` output, shows whether a conversion is still running. Each conversion lasts a fixed number of system clocks. During the first few clocks the converter's track/hold is told to sample. At the end the converter word is split into a low byte and a high part and stored in two buffer registers. A one-clock completion strobe is sent to the threshold comparators.

In continuous mode the sequencer starts conversions by itself. An interval counter is reloaded from `rate_i` at every start, and a new conversion begins when that counter runs out. While continuous mode is on, manual start writes are discarded so that the automatic spacing is never disturbed. Software that does not use the threshold interrupt can poll `busy_o` and read the buffers between conversions.

Top module: `adc_conv_seq`

## Requirements
- R1: Writing 1 to the start bit (`ctrl_wr_i`=1, `start_bit_i`=1) while idle with `cont_en_i`=0 raises `busy_o` on the next clock. `conv_start_o` is high for exactly that first busy cycle.
- R2: A write with `start_bit_i`=0 has no effect: `busy_o` stays 0 and no conversion starts.
- R3: `busy_o` stays high for exactly CONV_CYCLES (default 156) consecutive clocks per conversion.
- R4: A start write while `busy_o`=1 is ignored. The running conversion is neither restarted nor lengthened.
- R5: A start write while `cont_en_i`=1 is ignored. Only the interval counter launches conversions.
- R6: On the first clock with `busy_o`=0 after a conversion, `done_o` is high for one clock. On that same clock the buffers show the converter word sampled at the last busy cycle's closing edge: `buf_lo_o` = word[7:0] and `buf_hi_o` = word[DATA_W-1:8].
- R7: `buf_lo_o` and `buf_hi_o` do not change while `busy_o`=1.
- R8: `sample_o` is high during the first SAMPLE_CYCLES (default 4) clocks of each conversion and low otherwise.
- R9: With `cont_en_i`=1 and the sequencer idle, a conversion starts on the first clock. After that, starts follow every `rate_i` clocks. `rate_i` must exceed CONV_CYCLES.
- R10: Clearing `cont_en_i` stops further automatic starts. A conversion already running still completes normally.
- R11: After reset, `busy_o`, `conv_start_o`, `sample_o`, `done_o` and both buffers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Write strobe for the start/status bit |
| start_bit_i | input | 1 | Value written to the start/status bit |
| cont_en_i | input | 1 | Continuous conversion enable |
| rate_i | input | RATE_W | Clocks between automatic starts |
| adc_data_i | input | DATA_W | Behavioural converter output word |
| busy_o | output | 1 | Status bit: 1 while converting |
| conv_start_o | output | 1 | One-clock start pulse to the converter |
| sample_o | output | 1 | Track/hold sample window |
| done_o | output | 1 | One-clock completion strobe |
| buf_lo_o | output | 8 | Result low byte |
| buf_hi_o | output | DATA_W-8 | Result high part |

## Verification
The assertions assume that `ctrl_wr_i` and `start_bit_i` are synchronous single-clock writes. They also assume that `rate_i` is larger than the conversion length whenever continuous mode is on. Under those conditions the status bit always drops for at least one clock between automatic conversions. The stimulus changes every input only on the falling clock edge. It programs only interval values from CONV_CYCLES+1 upward, and it changes `rate_i` while a conversion is running or the interval counter is active. The converter word changes on every clock, so a capture taken on the wrong edge shows up as a wrong buffer value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES   = 156,
  parameter int unsigned SAMPLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic sample_o,
  output logic conv_start_o,
  output logic last_o,
  output logic done_o
);
  localparam int unsigned CNT_W = cnt_width(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] SMP_LIM  = CNT_W'(CONV_CYCLES - SAMPLE_CYCLES);

  conv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CONV_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        CONV_IDLE: begin
          if (start_i) begin
            state_q <= CONV_RUN;
            cnt_q   <= CNT_INIT;
            start_q <= 1'b1;
          end
        end
        CONV_RUN: begin
          if (cnt_q == '0) begin
            state_q <= CONV_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= CONV_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == CONV_RUN);
  assign last_o       = busy_o && (cnt_q == '0);
  assign sample_o     = busy_o && (cnt_q >= SMP_LIM);
  assign conv_start_o = start_q;
  assign done_o       = done_q;
endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned RATE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_en_i,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expired_o
);
  logic [RATE_W-1:0] tmr_q;
  logic [RATE_W-1:0] reload;

  // counter reaches zero rate_i clocks after a start
  assign reload = (rate_i == '0) ? '0 : rate_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (!cont_en_i) begin
      tmr_q <= '0;
    end else if (start_i) begin
      tmr_q <= reload;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign expired_o = (tmr_q == '0);
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [7:0]        lo_o,
  output logic [DATA_W-9:0] hi_o
);
  localparam int unsigned HI_W = DATA_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (capture_i) begin
      lo_q <= data_i[7:0];
      hi_q <= data_i[DATA_W-1:8];
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned DATA_W        = 10,
  parameter int unsigned RATE_W        = 12,
  parameter int unsigned CONV_CYCLES   = 156,
  parameter int unsigned SAMPLE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              start_bit_i,
  input  logic              cont_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              busy_o,
  output logic              conv_start_o,
  output logic              sample_o,
  output logic              done_o,
  output logic [7:0]        buf_lo_o,
  output logic [DATA_W-9:0] buf_hi_o
);
  logic manual_req, auto_req, start, last, expired;

  // manual writes only count outside continuous mode
  assign manual_req = ctrl_wr_i && start_bit_i && !cont_en_i;
  assign auto_req   = cont_en_i && expired;
  assign start      = !busy_o && (manual_req || auto_req);

  adc_conv_timer #(
    .CONV_CYCLES  (CONV_CYCLES),
    .SAMPLE_CYCLES(SAMPLE_CYCLES)
  ) u_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .busy_o      (busy_o),
    .sample_o    (sample_o),
    .conv_start_o(conv_start_o),
    .last_o      (last),
    .done_o      (done_o)
  );

  adc_rate_timer #(
    .RATE_W(RATE_W)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cont_en_i(cont_en_i),
    .start_i  (start),
    .rate_i   (rate_i),
    .expired_o(expired)
  );

  adc_result_buf #(
    .DATA_W(DATA_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(last),
    .data_i   (adc_data_i),
    .lo_o     (buf_lo_o),
    .hi_o     (buf_hi_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned CONV_CYCLES = 156
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic              start_bit_i,
  input logic              cont_en_i,
  input logic              busy_o,
  input logic              conv_start_o,
  input logic              sample_o,
  input logic              done_o,
  input logic [7:0]        buf_lo_o,
  input logic [DATA_W-9:0] buf_hi_o
);
  logic [15:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else busy_len_q <= '0;
  end

  p_start_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> conv_start_o);
  p_pulse_on_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $rose(busy_o));
  p_zero_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !start_bit_i && !busy_o && !cont_en_i) |=> !busy_o);
  p_conv_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == 16'(CONV_CYCLES)));
  p_done_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_buf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(buf_lo_o) && $stable(buf_hi_o)));
  p_sample_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o);
  p_sample_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sample_o);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DATA_W     (DATA_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr_i),
  .start_bit_i (start_bit_i),
  .cont_en_i   (cont_en_i),
  .busy_o      (busy_o),
  .conv_start_o(conv_start_o),
  .sample_o    (sample_o),
  .done_o      (done_o),
  .buf_lo_o    (buf_lo_o),
  .buf_hi_o    (buf_hi_o)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  localparam int DATA_W = 10;
  localparam int RATE_W = 12;
  localparam int CONV   = 156;
  localparam int SMP    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0, bitv = 1'b0, cont = 1'b0;
  logic [RATE_W-1:0] rate = '0;
  logic [DATA_W-1:0] data = '0;
  logic              busy, cs, smp, done;
  logic [7:0]        lo;
  logic [DATA_W-9:0] hi;

  always #5 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(wr), .start_bit_i(bitv),
    .cont_en_i(cont), .rate_i(rate), .adc_data_i(data),
    .busy_o(busy), .conv_start_o(cs), .sample_o(smp), .done_o(done),
    .buf_lo_o(lo), .buf_hi_o(hi)
  );

  int    vectors = 0, miscomp = 0, cyc = 0;
  string phase = "R11 reset";

  // behavioural reference
  int m_busy, m_left, m_tmr, m_cs, m_done, m_word;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_tmr = 0; m_cs = 0; m_done = 0; m_word = 0;
    end else begin
      bit go;
      go = (m_busy == 0) && (cont ? (m_tmr == 0) : (wr && bitv));
      m_cs = 0; m_done = 0;
      if (!cont) m_tmr = 0;
      else if (go) m_tmr = (rate == 0) ? 0 : int'(rate) - 1;
      else if (m_tmr > 0) m_tmr = m_tmr - 1;
      if (go) begin
        m_busy = 1; m_left = CONV; m_cs = 1;
      end else if (m_busy != 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_word = int'(data);
        end
      end
    end
  end

  task automatic cmp(input string fld, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", phase, fld, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    cmp("busy_o R3", int'(busy), m_busy);
    cmp("conv_start_o R1", int'(cs), m_cs);
    cmp("sample_o R8", int'(smp), (m_busy != 0 && m_left > CONV - SMP) ? 1 : 0);
    cmp("done_o R6", int'(done), m_done);
    cmp("buf_lo_o R7", int'(lo), m_word & 8'hff);
    cmp("buf_hi_o R7", int'(hi), m_word >> 8);
    if (cyc == 60000) begin
      miscomp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  always @(negedge clk) data <= DATA_W'((int'(data) * 5 + 7) % 1021);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_bit(input logic b);
    @(negedge clk); wr = 1'b1; bitv = b;
    @(negedge clk); wr = 1'b0; bitv = 1'b0;
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    phase = "R1 manual start";
    write_bit(1'b1); idle(170);
    phase = "R2 zero write";
    write_bit(1'b0); idle(6);
    phase = "R4 start while busy";
    write_bit(1'b1); idle(40);
    write_bit(1'b1); idle(100);
    write_bit(1'b1); idle(30);
    phase = "R6 back to back manual";
    write_bit(1'b1); idle(156);
    write_bit(1'b1); idle(165);
    phase = "R9 continuous 200";
    @(negedge clk); rate = 12'd200; cont = 1'b1;
    idle(170);
    phase = "R5 write in continuous";
    write_bit(1'b1); idle(15);
    write_bit(1'b1); idle(400);
    phase = "R9 continuous 157";
    @(negedge clk); rate = 12'd157;
    idle(700);
    phase = "R10 disable mid conversion";
    @(negedge clk); rate = 12'd300;
    idle(320);
    @(negedge clk); cont = 1'b0;
    idle(400);
    phase = "R9 re-enable";
    @(negedge clk); cont = 1'b1; rate = 12'd180;
    idle(500);
    @(negedge clk); cont = 1'b0;
    idle(200);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule